// File: doc/BRIEF.md
# Two-Tier Shared Bus Arbiter

This block decides which of several modules may drive a shared parallel bus. Modules sit on four request levels, and several modules may share one level. A module asks for the bus by pulling its slot's active-low request line. A level counts as requesting when any of its slots pulls low, which models a wired line that any of them can hold down. Every request line, and the bus-busy line, is asynchronous to the arbiter clock and goes through a two-stage synchroniser before the arbiter looks at it.

When the bus is free, the arbiter picks one requesting level. A mode input selects the policy: a fixed order in which level 3 ranks highest, or a rotating order in which the most recently granted level ranks last. The arbiter then offers the grant along that level's daisy chain. Slot 0 is nearest to the arbiter. The grant moves on by one slot per clock and stops at the first slot that is requesting. The winner raises the busy line when it takes over the bus. The arbiter then drops its grants and issues no new grant until busy falls again.

Top module: `lvl_bus_arbiter`

## Requirements
- R1: After reset no level grant and no slot grant is driven. A level counts as requesting when any of its slots holds its request line low. The slot index is level*SLOTS + position, and position 0 is nearest the arbiter.
- R2: With rr_mode_i = 0, the highest-numbered requesting level is chosen. Level 3 is the highest and level 0 the lowest.
- R3: With rr_mode_i = 1, levels are searched downward, wrapping round, starting one below the last granted level. The last granted level therefore comes last. After reset the last granted level reads as 0, so the first search order is 3,2,1,0. Grants in either mode update the last granted level.
- R4: Within the chosen level, the requesting slot with the lowest position receives the slot grant.
- R5: Starting from idle with the bus free, lvl_grant_o shows the chosen level 3 clock edges after a request is applied. The slot grant for position p appears 4+p edges after the request, because each non-requesting slot costs one clock.
- R6: While the synchronised busy is high, no arbitration starts. Once a slot grant is shown, grants drop 3 edges after bus_busy_i rises.
- R7: At most one level grant and at most one slot grant are active at any time. A slot grant only ever appears within the level that is granted.
- R8: A slot grant is held for as long as its slot keeps requesting and busy stays low. It drops 3 edges after the request is withdrawn. If the walk passes the last slot without finding a requester, the arbiter returns to idle.
- R9: A request or busy change has no effect before it has passed two synchroniser flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Arbiter sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_req_n_i | input | NUM_LVL*SLOTS | Active-low request per daisy-chain slot, asynchronous |
| bus_busy_i | input | 1 | Bus in use by the current owner, active high, asynchronous |
| rr_mode_i | input | 1 | 1 selects rotating level order, 0 selects fixed order |
| lvl_grant_o | output | NUM_LVL | One-hot grant for the chosen level |
| slot_grant_o | output | NUM_LVL*SLOTS | One-hot grant for the slot that won the daisy chain |

## Verification
The assertions assume that the mode input stays constant from one clock to the next around an arbitration decision. They also assume that busy is raised only by the module that holds a slot grant. The stimulus changes the mode only while the bus is busy or idle with no requests pending. Busy is raised only after a slot grant has been seen, and all requests are released at the same moment, so the timing windows checked for levels, positions and handoff stay deterministic.

// File: rtl/lvl_arb_pkg.sv
package lvl_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_OFFER = 2'd2,
        ST_OWNED = 2'd3
    } arb_st_e;

endpackage

// File: rtl/lvl_arb_sync.sv
module lvl_arb_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
    } sync_s;

    sync_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = async_i;
        s_d.stab = s_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sync_o = s_q.stab;

    // R9: output follows input exactly two edges later
    p_two_stage_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.meta == $past(async_i) |=> sync_o == $past(async_i, 2));

endmodule

// File: rtl/lvl_arb_pick.sv
module lvl_arb_pick #(
    parameter int NUM_LVL = 4,
    localparam int LW     = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic [NUM_LVL-1:0] lvl_act_i,
    input  logic [LW-1:0]      last_i,
    input  logic               rr_mode_i,
    output logic [LW-1:0]      pick_o,
    output logic               vld_o
);

    always_comb begin
        pick_o = '0;
        vld_o  = 1'b0;
        for (int i = 1; i <= NUM_LVL; i++) begin
            int cand;
            if (rr_mode_i) cand = (int'(last_i) + NUM_LVL - i) % NUM_LVL;
            else           cand = NUM_LVL - i;
            if (!vld_o && lvl_act_i[cand]) begin
                vld_o  = 1'b1;
                pick_o = LW'(cand);
            end
        end
    end

endmodule

// File: rtl/lvl_arb_core.sv
module lvl_arb_core
    import lvl_arb_pkg::*;
#(
    parameter int NUM_LVL = 4,
    parameter int SLOTS   = 3,
    localparam int LW     = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int PW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int NSL    = NUM_LVL * SLOTS,
    localparam int IW     = (NSL > 1) ? $clog2(NSL) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_LVL-1:0] lvl_act_i,
    input  logic [NSL-1:0]     slot_req_i,
    input  logic               busy_i,
    input  logic               rr_mode_i,
    input  logic [LW-1:0]      pick_i,
    input  logic               pick_vld_i,
    output logic [LW-1:0]      last_o,
    output logic [NUM_LVL-1:0] lvl_grant_o,
    output logic [NSL-1:0]     slot_grant_o
);

    typedef struct packed {
        arb_st_e       st;
        logic [LW-1:0] lvl;
        logic [PW-1:0] pos;
        logic [LW-1:0] last;
    } core_s;

    core_s r_d, r_q;
    logic [IW-1:0] cur_idx;
    logic          cur_req;
    logic          at_end;

    always_comb begin
        cur_idx = IW'(int'(r_q.lvl) * SLOTS + int'(r_q.pos));
        cur_req = slot_req_i[cur_idx];
        at_end  = (int'(r_q.pos) == SLOTS - 1);

        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!busy_i && pick_vld_i) begin
                    r_d.st   = ST_WALK;
                    r_d.lvl  = pick_i;
                    r_d.pos  = '0;
                    r_d.last = pick_i;
                end
            end
            ST_WALK: begin
                if (busy_i)       r_d.st  = ST_IDLE;
                else if (cur_req) r_d.st  = ST_OFFER;
                else if (at_end)  r_d.st  = ST_IDLE;
                else              r_d.pos = r_q.pos + 1'b1;
            end
            ST_OFFER: begin
                if (busy_i)        r_d.st = ST_OWNED;
                else if (!cur_req) r_d.st = ST_IDLE;
            end
            ST_OWNED: begin
                if (!busy_i) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st   <= ST_IDLE;
            r_q.lvl  <= '0;
            r_q.pos  <= '0;
            r_q.last <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        lvl_grant_o  = '0;
        slot_grant_o = '0;
        if (r_q.st == ST_WALK || r_q.st == ST_OFFER)
            lvl_grant_o = NUM_LVL'(1) << r_q.lvl;
        if (r_q.st == ST_OFFER)
            slot_grant_o = NSL'(1) << cur_idx;
    end

    assign last_o = r_q.last;

    // R6: a busy bus keeps the arbiter idle
    p_no_start_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_IDLE && busy_i) |=> r_q.st == ST_IDLE);

    // R2: fixed order never skips a higher active level
    p_fixed_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_IDLE && !busy_i && !rr_mode_i && |lvl_act_i)
        |=> r_q.st == ST_WALK &&
            (($past(lvl_act_i) >> ({1'b0, r_q.lvl} + 1'b1)) == '0));

    // R5: an idle slot hands on the grant in a single clock
    p_pass_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_WALK && !busy_i && !cur_req && !at_end)
        |=> r_q.st == ST_WALK && r_q.pos == $past(r_q.pos) + 1'b1);

    // R8: an offered grant stays while its slot still wants it
    p_hold_offer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_OFFER && !busy_i && cur_req) |=> r_q.st == ST_OFFER);

    // R4: the walk starts at the nearest slot
    p_walk_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(r_q.st == ST_WALK) |-> r_q.pos == '0);

endmodule

// File: rtl/lvl_bus_arbiter.sv
module lvl_bus_arbiter #(
    parameter int NUM_LVL = 4,
    parameter int SLOTS   = 3,
    localparam int LW     = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int NSL    = NUM_LVL * SLOTS
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NSL-1:0]     slot_req_n_i,
    input  logic               bus_busy_i,
    input  logic               rr_mode_i,
    output logic [NUM_LVL-1:0] lvl_grant_o,
    output logic [NSL-1:0]     slot_grant_o
);

    logic [NSL-1:0]     req_s;
    logic               busy_s;
    logic [NUM_LVL-1:0] lvl_act;
    logic [LW-1:0]      last_lvl;
    logic [LW-1:0]      pick;
    logic               pick_vld;

    lvl_arb_sync #(.WIDTH(NSL + 1)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({bus_busy_i, ~slot_req_n_i}),
        .sync_o  ({busy_s, req_s})
    );

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        assign lvl_act[l] = |req_s[l*SLOTS +: SLOTS];

        // R7: a slot grant lies inside the granted level
        p_slot_in_lvl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            |slot_grant_o[l*SLOTS +: SLOTS] |-> lvl_grant_o[l]);
    end

    lvl_arb_pick #(.NUM_LVL(NUM_LVL)) u_pick (
        .lvl_act_i (lvl_act),
        .last_i    (last_lvl),
        .rr_mode_i (rr_mode_i),
        .pick_o    (pick),
        .vld_o     (pick_vld)
    );

    lvl_arb_core #(.NUM_LVL(NUM_LVL), .SLOTS(SLOTS)) u_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .lvl_act_i    (lvl_act),
        .slot_req_i   (req_s),
        .busy_i       (busy_s),
        .rr_mode_i    (rr_mode_i),
        .pick_i       (pick),
        .pick_vld_i   (pick_vld),
        .last_o       (last_lvl),
        .lvl_grant_o  (lvl_grant_o),
        .slot_grant_o (slot_grant_o)
    );

    // R7: single level grant, single slot grant
    p_one_lvl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(lvl_grant_o));
    p_one_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(slot_grant_o));

    // R6: once the owner is busy no grant is presented
    p_busy_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_s && $past(busy_s) && lvl_grant_o == '0) |=> lvl_grant_o == '0 || !busy_s);

endmodule

// File: tb/lvl_bus_arbiter_tb.sv
module lvl_bus_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NL  = 4;
    localparam int NS  = 3;
    localparam int NSL = NL * NS;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NSL-1:0] req_n = '1;
    logic           busy = 1'b0;
    logic           rr = 1'b0;
    logic [NL-1:0]  lvl_g;
    logic [NSL-1:0] slot_g;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_bus_arbiter #(.NUM_LVL(NL), .SLOTS(NS)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .slot_req_n_i (req_n),
        .bus_busy_i   (busy),
        .rr_mode_i    (rr),
        .lvl_grant_o  (lvl_g),
        .slot_grant_o (slot_g)
    );

    // {rr mode, active-high request mask, expected slot index}
    localparam logic [16:0] VEC [10] = '{
        {1'b0, 12'h0A0, 4'd7},
        {1'b0, 12'hC01, 4'd10},
        {1'b1, 12'h208, 4'd3},
        {1'b1, 12'h214, 4'd2},
        {1'b1, 12'h801, 4'd11},
        {1'b1, 12'h240, 4'd6},
        {1'b1, 12'h480, 4'd10},
        {1'b0, 12'h002, 4'd1},
        {1'b0, 12'hFFF, 4'd9},
        {1'b1, 12'h1E0, 4'd6}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        step(1);
        check(lvl_g == '0 && slot_g == '0, "R1 reset grants", int'(slot_g), 0);
        step(2);
        rst_n = 1'b1;
        step(1);

        // latency through sync and chain: level 1, position 2 (slot 5)
        req_n = ~NSL'(12'h020);
        step(2);
        check(lvl_g == '0, "R9 not before sync", int'(lvl_g), 0);
        step(1);
        check(lvl_g == 4'b0010, "R5 level grant edge 3", int'(lvl_g), 2);
        step(2);
        check(slot_g == '0, "R5 no slot before edge 6", int'(slot_g), 0);
        step(1);
        check(slot_g == NSL'(12'h020), "R5 slot grant edge 6", int'(slot_g), 32);

        // hold then withdrawal
        step(8);
        check(slot_g == NSL'(12'h020), "R8 grant held", int'(slot_g), 32);
        req_n = '1;
        step(2);
        check(slot_g == NSL'(12'h020), "R8 held through sync", int'(slot_g), 32);
        step(1);
        check(slot_g == '0 && lvl_g == '0, "R8 drop after withdraw", int'(slot_g), 0);

        // busy holds off arbitration
        busy = 1'b1;
        step(4);
        req_n = ~NSL'(12'h001);
        step(12);
        check(lvl_g == '0, "R6 no grant while busy", int'(lvl_g), 0);
        busy = 1'b0;
        step(3);
        check(lvl_g == 4'b0001, "R6 grant after release", int'(lvl_g), 1);
        step(1);
        check(slot_g == NSL'(12'h001), "R4 nearest slot", int'(slot_g), 1);
        busy = 1'b1;
        step(2);
        check(slot_g == NSL'(12'h001), "R6 grant before busy sync", int'(slot_g), 1);
        step(1);
        check(slot_g == '0 && lvl_g == '0, "R6 grants drop on busy", int'(lvl_g), 0);
        req_n = '1;
        step(3);

        // policy table: each vector starts as busy falls
        for (int v = 0; v < 10; v++) begin
            int exp_s;
            int got;
            int waited;
            exp_s = int'(VEC[v][3:0]);
            rr    = VEC[v][16];
            req_n = ~VEC[v][15:4];
            busy  = 1'b0;
            waited = 0;
            while (slot_g == '0 && waited < 40) begin
                step(1);
                waited++;
            end
            got = -1;
            for (int b = 0; b < NSL; b++) if (slot_g[b]) got = b;
            check(got == exp_s, VEC[v][16] ? "R3 rotating pick" : "R2 fixed pick", got, exp_s);
            check(lvl_g == (NL'(1) << (exp_s / NS)), "R7 level of winner", int'(lvl_g), 1 << (exp_s / NS));
            busy  = 1'b1;
            req_n = '1;
            step(5);
            check(slot_g == '0 && lvl_g == '0, "R6 idle while owned", int'(slot_g), 0);
        end

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

endmodule